// File: doc/BRIEF.md
# Paged Command I2C Master

This block is an I2C bus master that software drives through four 32-bit registers: a configuration register, a command register and two page registers. Software performs a transfer as a series of single bus primitives (START, STOP, a WRITE of one to eight bytes, or a READ of one to eight bytes). For each primitive it writes the command register with the trigger bit set, then polls until that bit reads back clear.

A WRITE shifts bytes out of the 8-byte page held in the two page registers. It records whether the target acknowledged each byte in an 8-bit acknowledge field. A READ shifts received bytes into the same page positions. The master acknowledges every byte, except that one read variant answers the final byte with a NACK so that the target releases the bus.

SCL is produced by a programmable divider. The high phase can be stretched by the target. Both lines are driven either open-drain or push-pull, through separate output-enable and output-level pins.

Register addresses (`reg_addr`): 0 = configuration, 1 = command, 2 = page low (bytes 0 to 3), 3 = page high (bytes 4 to 7). Reads return the selected register one clock after the address is presented.

Top module: `i2c_page_master`

## Requirements
- R1: After reset, the command register reads 0. The configuration register reads 0 except for the two live line-level bits. A write to configuration stores drive mode in bit 31, the divider in bits 26:16, enable in bit 1 and stretch enable in bit 0, and reads back the same fields.
- R2: A command-register write launches a primitive when bit 0 is 1, the code in bits 6:4 is 1 to 5, the block is enabled and it is idle. Bit 0 reads 1 while the primitive runs. With no stretching, a primitive lasts exactly slots × (divider+1) clocks: one slot for START or STOP, nine slots per byte for WRITE or READ.
- R3: Each slot holds SCL low for floor((divider+1)/2) clocks and then releases it for the rest of the slot. SCL stays released while the block is idle.
- R4: Code 1 (START) takes SDA from high to low while SCL is high. Code 3 (STOP) takes SDA from low to high while SCL is high.
- R5: Code 2 (WRITE) sends bytes 0 to N−1, most significant bit first. Byte k is taken from page-low bits 8k+7:8k for k < 4, and from page-high bits for bytes 4 to 7. SDA is released during each acknowledge slot.
- R6: Command-register bits 23:16 are cleared when a WRITE launches. After the WRITE, bit 16+k is 1 exactly when the target pulled SDA low in the acknowledge slot of byte k.
- R7: A READ (code 4 or 5) releases SDA during data bits. It stores each received byte, first bit as the MSB, into the same page position a WRITE would send it from, and leaves the other page bytes unchanged.
- R8: During a READ the master drives ACK (low) after every byte except the last. After the last byte it drives NACK (high) for code 4 and ACK for code 5.
- R9: With stretch enable set, the high phase of a slot waits until SCL is sampled high. A target that holds SCL low for H clocks from the slot start (H > half period) lengthens that slot by H − floor((divider+1)/2) clocks. With stretch enable clear, the slot length is unchanged.
- R10: With configuration bit 31 clear, an output enable is asserted only to pull a line low, and the output level is 0. With bit 31 set, both enables are always 1 and the output levels carry the line values.
- R11: Configuration bits 3 and 2 read back the sampled SCL and SDA line levels.
- R12: The following command-register writes are ignored: writes while the busy bit is set, triggers with codes 0, 6 or 7, and triggers while enable is clear. Ignored writes start no bus activity, and writes made while busy leave the stored command and length unchanged.
- R13: Command-register bits 10:8 hold the byte count minus one and read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data of the selected register |
| scl_i | input | 1 | SCL line level |
| scl_o | output | 1 | SCL output level |
| scl_oe | output | 1 | SCL output enable |
| sda_i | input | 1 | SDA line level |
| sda_o | output | 1 | SDA output level |
| sda_oe | output | 1 | SDA output enable |

## Verification
The SCL line is predicted every clock from a slot counter kept in the bench. This exposes any error in phase length, slot count or end-of-primitive timing.

WRITE is tried with a partial page under a mixed acknowledge pattern, a full eight-byte page acknowledged throughout, and a single byte that is never acknowledged. Together these separate byte ordering across both page registers, per-byte acknowledge capture, and clearing of stale acknowledge bits.

READ is tried with both codes so that the final NACK is told apart from ACK. Stretching is measured with the stretch option both on and off. The ignore rules are tested with a write made mid-primitive, an invalid code, and a trigger while the block is disabled.

// File: rtl/i2c_pm_pkg.sv
package i2c_pm_pkg;
  localparam int PAGE_BYTES = 8;
  localparam int IDX_W      = $clog2(PAGE_BYTES);
  localparam int PAGE_W     = PAGE_BYTES * 8;

  typedef enum logic [2:0] {
    CMD_NONE    = 3'd0,
    CMD_START   = 3'd1,
    CMD_WRITE   = 3'd2,
    CMD_STOP    = 3'd3,
    CMD_RD_NACK = 3'd4,
    CMD_RD_ACK  = 3'd5
  } cmd_e;

  function automatic logic cmd_ok(input logic [2:0] c);
    return (c >= 3'd1) && (c <= 3'd5);
  endfunction
endpackage

// File: rtl/i2c_pm_timer.sv
module i2c_pm_timer #(
  parameter int DIV_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             launch,
  input  logic             run,
  input  logic             stretch_en,
  input  logic             scl_s,
  input  logic [DIV_W-1:0] div,
  output logic             scl_low,
  output logic             slot_end,
  output logic             tick_a,
  output logic             tick_b
);
  localparam int CW = DIV_W + 1;

  logic [DIV_W-1:0] cnt;
  logic [CW-1:0]    half, quarter, cnt_x;
  logic             hold, advance;

  always_comb begin
    half     = ({1'b0, div} + CW'(1)) >> 1;
    quarter  = half >> 1;
    cnt_x    = {1'b0, cnt};
    // stretch: freeze in the high phase until the line is seen high
    hold     = stretch_en && !scl_s && (cnt_x > half);
    advance  = run && !hold;
    scl_low  = cnt_x < half;
    slot_end = advance && (cnt >= div);
    tick_a   = advance && (cnt_x == quarter);
    tick_b   = advance && (cnt_x == half + quarter);
  end

  always_ff @(posedge clk) begin
    if (rst)           cnt <= '0;
    else if (launch)   cnt <= '0;
    else if (slot_end) cnt <= '0;
    else if (advance)  cnt <= cnt + 1'b1;
  end

  // R3: a slot always ends in its high phase
  p_end_in_high_r3: assert property (@(posedge clk) disable iff (rst)
    slot_end |-> !scl_low);
endmodule

// File: rtl/i2c_pm_engine.sv
module i2c_pm_engine
  import i2c_pm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              launch,
  input  logic [2:0]        cmd,
  input  logic [IDX_W-1:0]  last_idx,
  input  logic [PAGE_W-1:0] page_in,
  input  logic              scl_low,
  input  logic              slot_end,
  input  logic              tick_a,
  input  logic              tick_b,
  input  logic              sda_s,
  output logic              busy,
  output logic              sda_rel,
  output logic              byte_we,
  output logic [IDX_W-1:0]  byte_idx,
  output logic [7:0]        byte_val,
  output logic              ack_we,
  output logic [IDX_W-1:0]  ack_idx,
  output logic              ack_val
);
  cmd_e             cmd_q;
  logic [IDX_W-1:0] last_q, bi;
  logic [3:0]       bt;
  logic [7:0]       shreg;
  logic             is_ack, is_wr, edge_cmd, wbit, mack, val_a, val_b;

  always_comb begin
    is_ack   = (bt == 4'd8);
    is_wr    = (cmd_q == CMD_WRITE);
    edge_cmd = (cmd_q == CMD_START) || (cmd_q == CMD_STOP);
    wbit     = page_in[{bi, ~bt[2:0]}];
    mack     = (cmd_q == CMD_RD_NACK) && (bi == last_q);
    unique case (cmd_q)
      CMD_START: begin val_a = 1'b1; val_b = 1'b0; end
      CMD_STOP:  begin val_a = 1'b0; val_b = 1'b1; end
      CMD_WRITE: begin val_a = is_ack | wbit; val_b = val_a; end
      default:   begin val_a = is_ack ? mack : 1'b1; val_b = val_a; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0; sda_rel <= 1'b1; cmd_q <= CMD_NONE;
      last_q <= '0; bi <= '0; bt <= '0; shreg <= '0;
      byte_we <= 1'b0; byte_idx <= '0; byte_val <= '0;
      ack_we <= 1'b0; ack_idx <= '0; ack_val <= 1'b0;
    end else begin
      byte_we <= 1'b0;
      ack_we  <= 1'b0;
      if (launch) begin
        busy <= 1'b1; cmd_q <= cmd_e'(cmd); last_q <= last_idx;
        bi <= '0; bt <= '0;
      end else if (busy) begin
        if (tick_a) sda_rel <= val_a;
        if (tick_b) sda_rel <= val_b;
        if (slot_end) begin
          if (edge_cmd) begin
            busy <= 1'b0;
          end else if (is_ack) begin
            if (is_wr) begin
              ack_we <= 1'b1; ack_idx <= bi; ack_val <= ~sda_s;
            end
            bt <= '0;
            if (bi == last_q) busy <= 1'b0;
            else              bi <= bi + 1'b1;
          end else begin
            shreg <= {shreg[6:0], sda_s};
            if (bt == 4'd7 && !is_wr) begin
              byte_we <= 1'b1; byte_idx <= bi; byte_val <= {shreg[6:0], sda_s};
            end
            bt <= bt + 1'b1;
          end
        end
      end
    end
  end

  // R5: a written bit holds steady on SDA while SCL is high
  p_data_steady_r5: assert property (@(posedge clk) disable iff (rst)
    (busy && is_wr && !scl_low && !launch) |=> $stable(sda_rel));
  // R2: a primitive only finishes at a slot boundary
  p_done_at_slot_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(slot_end));
endmodule

// File: rtl/i2c_page_master.sv
module i2c_page_master
  import i2c_pm_pkg::*;
#(
  parameter int DIV_W = 11
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_we,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        scl_i,
  output logic        scl_o,
  output logic        scl_oe,
  input  logic        sda_i,
  output logic        sda_o,
  output logic        sda_oe
);
  localparam int DIV_LSB = 16;

  logic                  pp, en, str_en, scl_s, sda_s;
  logic [DIV_W-1:0]      div;
  logic [2:0]            cmd_r;
  logic [IDX_W-1:0]      len_r;
  logic [PAGE_BYTES-1:0] ack_r;
  logic [PAGE_W-1:0]     page;
  logic                  busy, sda_rel, scl_low, slot_end, tick_a, tick_b;
  logic                  byte_we, ack_we, ack_val, launch, c1_wr, scl_pull, sda_pull;
  logic [IDX_W-1:0]      byte_idx, ack_idx;
  logic [7:0]            byte_val;
  logic [31:0]           c0_view, c1_view;

  assign c1_wr  = reg_we && (reg_addr == 2'd1);
  assign launch = c1_wr && reg_wdata[0] && !busy && en && cmd_ok(reg_wdata[6:4]);

  always_ff @(posedge clk) begin
    if (rst) begin
      pp <= 1'b0; en <= 1'b0; str_en <= 1'b0; div <= '0;
      cmd_r <= '0; len_r <= '0; ack_r <= '0; page <= '0;
      scl_s <= 1'b1; sda_s <= 1'b1;
    end else begin
      scl_s <= scl_i;
      sda_s <= sda_i;
      if (reg_we && reg_addr == 2'd0) begin
        pp <= reg_wdata[31]; div <= reg_wdata[DIV_LSB +: DIV_W];
        en <= reg_wdata[1];  str_en <= reg_wdata[0];
      end
      if (c1_wr && !busy) begin
        cmd_r <= reg_wdata[6:4]; len_r <= reg_wdata[8 +: IDX_W];
      end
      if (launch && reg_wdata[6:4] == CMD_WRITE) ack_r <= '0;
      else if (ack_we) ack_r[ack_idx] <= ack_val;
      if (reg_we && reg_addr == 2'd2) page[31:0]  <= reg_wdata;
      if (reg_we && reg_addr == 2'd3) page[63:32] <= reg_wdata;
      if (byte_we) page[{byte_idx, 3'b000} +: 8] <= byte_val;
    end
  end

  always_comb begin
    c0_view = '0;
    c0_view[31] = pp;
    c0_view[DIV_LSB +: DIV_W] = div;
    c0_view[3] = scl_s; c0_view[2] = sda_s; c0_view[1] = en; c0_view[0] = str_en;
    c1_view = '0;
    c1_view[16 +: PAGE_BYTES] = ack_r;
    c1_view[8 +: IDX_W] = len_r;
    c1_view[6:4] = cmd_r;
    c1_view[0] = busy;
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else begin
      unique case (reg_addr)
        2'd0: reg_rdata <= c0_view;
        2'd1: reg_rdata <= c1_view;
        2'd2: reg_rdata <= page[31:0];
        default: reg_rdata <= page[63:32];
      endcase
    end
  end

  i2c_pm_timer #(.DIV_W(DIV_W)) u_timer (
    .clk(clk), .rst(rst), .launch(launch), .run(busy), .stretch_en(str_en),
    .scl_s(scl_s), .div(div), .scl_low(scl_low), .slot_end(slot_end),
    .tick_a(tick_a), .tick_b(tick_b));

  i2c_pm_engine u_engine (
    .clk(clk), .rst(rst), .launch(launch), .cmd(reg_wdata[6:4]),
    .last_idx(reg_wdata[8 +: IDX_W]), .page_in(page), .scl_low(scl_low),
    .slot_end(slot_end), .tick_a(tick_a), .tick_b(tick_b), .sda_s(sda_s),
    .busy(busy), .sda_rel(sda_rel), .byte_we(byte_we), .byte_idx(byte_idx),
    .byte_val(byte_val), .ack_we(ack_we), .ack_idx(ack_idx), .ack_val(ack_val));

  assign scl_pull = busy && scl_low;
  assign sda_pull = !sda_rel;
  assign scl_oe   = pp | scl_pull;
  assign scl_o    = pp & ~scl_pull;
  assign sda_oe   = pp | sda_pull;
  assign sda_o    = pp & ~sda_pull;

  // R12: command writes during a primitive do not alter the stored command
  p_busy_ignore_r12: assert property (@(posedge clk) disable iff (rst)
    (busy && c1_wr) |=> ($stable(cmd_r) && $stable(len_r)));
  // R6: a launched WRITE starts from an empty acknowledge field
  p_ack_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (launch && reg_wdata[6:4] == CMD_WRITE) |=> (ack_r == '0));
  // R10: in open-drain mode an idle master leaves SCL undriven
  p_idle_release_r10: assert property (@(posedge clk) disable iff (rst)
    (!pp && !busy) |-> !scl_oe);
endmodule

// File: tb/i2c_page_master_test.sv
module i2c_page_master_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_we = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic scl_o, scl_oe, sda_o, sda_oe, scl_line, sda_line;
  logic tgt_scl_low = 1'b0, tgt_sda_low = 1'b0, force_sda = 1'b0;

  int n_tests = 0, n_fail = 0;
  int P = 10, HALF = 5;
  int tmode = 0, tn = 0, tgt_gen = 0;
  logic [7:0] ackmask = '0;
  logic [7:0] txb [8];
  logic mid  [72];
  logic endv [72];

  always #2.5 clk = ~clk;

  assign scl_line = (scl_oe ? scl_o : 1'b1) & ~tgt_scl_low;
  assign sda_line = (sda_oe ? sda_o : 1'b1) & ~tgt_sda_low & ~force_sda;

  i2c_page_master uut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .scl_i(scl_line),
    .scl_o(scl_o), .scl_oe(scl_oe), .sda_i(sda_line), .sda_o(sda_o),
    .sda_oe(sda_oe));

  // behavioural target: acts on each SCL fall, slot count restarts per primitive
  int seen_gen = 0, tslot = 0;
  logic prev_scl = 1'b1;
  always @(negedge clk) begin
    if (tgt_gen != seen_gen) begin seen_gen = tgt_gen; tslot = 0; end
    if (prev_scl && !scl_line) begin
      int by, bt;
      logic drv;
      by = tslot / 9; bt = tslot % 9; drv = 1'b0;
      if (tmode == 1 && by < tn && bt == 8) drv = ackmask[by];
      if (tmode == 2 && by < tn && bt < 8)  drv = !txb[by][7-bt];
      tgt_sda_low <= drv;
      tslot++;
    end
    prev_scl = scl_line;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    reg_addr = a;
    @(negedge clk);
    v = reg_rdata;
  endtask

  task automatic target(input int mode, input int nbytes);
    tmode = mode; tn = nbytes; tgt_gen++;
  endtask

  // per-clock reference for SCL, with SDA captured at mid-high and end-of-slot
  task automatic run_prim(input logic [31:0] c1, input int slots, input string tag);
    int mism;
    logic [31:0] v;
    mism = 0;
    wr(2'd1, c1);
    for (int t = 0; t < slots * P; t++) begin
      int k, s;
      k = t % P; s = t / P;
      if (scl_line !== (k >= HALF)) mism++;
      if (k == HALF + 1) mid[s] = sda_line;
      if (k == P - 1) endv[s] = sda_line;
      @(negedge clk);
    end
    if (scl_line !== 1'b1) mism++;
    chk(mism == 0, {"R3 R2 scl waveform ", tag}, mism, 0);
    rd(2'd1, v);
    chk(v[0] == 1'b0, {"R2 busy clear ", tag}, v, 0);
  endtask

  function automatic logic [7:0] sent_byte(input int i);
    logic [7:0] b;
    for (int j = 0; j < 8; j++) b[7-j] = endv[i*9+j];
    return b;
  endfunction

  task automatic idle_check(input string tag);
    int bad;
    logic [31:0] v;
    bad = 0;
    for (int i = 0; i < 20; i++) begin
      if (scl_line !== 1'b1) bad++;
      @(negedge clk);
    end
    rd(2'd1, v);
    chk(bad == 0 && v[0] == 1'b0, {"R12 ", tag}, v, 0);
  endtask

  task automatic stretch_period(output int n);
    wr(2'd1, 32'h0000_0021);
    tgt_scl_low = 1'b1;
    repeat (HALF + 4) @(negedge clk);
    tgt_scl_low = 1'b0;
    #1;
    n = HALF + 4;
    while (scl_line !== 1'b0 && n < 100) begin
      @(negedge clk);
      n++;
    end
    repeat (9 * P + 20) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R2 watchdog act=%h exp=%h", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int n;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    rd(2'd1, v); chk(v == 32'h0, "R1 command reset", v, 32'h0);
    rd(2'd0, v); chk(v == 32'h0000_000C, "R1 R11 config reset", v, 32'h0000_000C);
    chk(!scl_oe && !sda_oe, "R10 lines released after reset", {scl_oe, sda_oe}, 0);

    wr(2'd0, 32'h0009_0002);
    rd(2'd0, v); chk(v == 32'h0009_000E, "R1 config readback", v, 32'h0009_000E);

    target(0, 0);
    run_prim(32'h0000_0011, 1, "start");
    chk(mid[0] == 1'b1 && endv[0] == 1'b0, "R4 start edge", {mid[0], endv[0]}, 2'b10);

    wr(2'd2, 32'h44A5_3C96); wr(2'd3, 32'h1122_3344);
    ackmask = 8'b0000_0101; target(1, 3);
    run_prim(32'h0000_0221, 27, "write3");
    chk(sent_byte(0) == 8'h96, "R5 byte0", sent_byte(0), 8'h96);
    chk(sent_byte(1) == 8'h3C && sent_byte(2) == 8'hA5, "R5 bytes1-2",
        {sent_byte(1), sent_byte(2)}, 16'h3CA5);
    chk(endv[17] == 1'b1, "R5 sda released in ack slot", endv[17], 1);
    rd(2'd1, v);
    chk(v[23:16] == 8'h05, "R6 ack field mixed", v[23:16], 8'h05);
    chk(v[10:8] == 3'd2 && v[6:4] == 3'd2, "R13 length field", v[10:8], 2);

    wr(2'd2, 32'h8765_4321); wr(2'd3, 32'hFEDC_BA98);
    ackmask = 8'hFF; target(1, 8);
    run_prim(32'h0000_0721, 72, "write8");
    chk(sent_byte(4) == 8'h98 && sent_byte(7) == 8'hFE, "R5 high page order",
        {sent_byte(4), sent_byte(7)}, 16'h98FE);
    rd(2'd1, v); chk(v[23:16] == 8'hFF, "R6 ack field full", v[23:16], 8'hFF);
    ackmask = 8'h00; target(1, 1);
    run_prim(32'h0000_0021, 9, "write1");
    rd(2'd1, v); chk(v[23:16] == 8'h00, "R6 ack field cleared", v[23:16], 8'h00);

    target(0, 0);
    run_prim(32'h0000_0011, 1, "restart");
    txb[0] = 8'h5A; txb[1] = 8'hC3; txb[2] = 8'h0F; target(2, 3);
    run_prim(32'h0000_0241, 27, "read nack");
    chk(endv[8] == 1'b0 && endv[17] == 1'b0 && endv[26] == 1'b1, "R8 final nack",
        {endv[8], endv[17], endv[26]}, 3'b001);
    rd(2'd2, v); chk(v == 32'h870F_C35A, "R7 read data", v, 32'h870F_C35A);
    txb[0] = 8'hFF; txb[1] = 8'h81; target(2, 2);
    run_prim(32'h0000_0151, 18, "read ack");
    chk(endv[8] == 1'b0 && endv[17] == 1'b0, "R8 all ack", {endv[8], endv[17]}, 0);
    rd(2'd2, v); chk(v == 32'h870F_81FF, "R7 read data keep", v, 32'h870F_81FF);

    target(0, 0);
    run_prim(32'h0000_0031, 1, "stop");
    chk(mid[0] == 1'b0 && endv[0] == 1'b1, "R4 stop edge", {mid[0], endv[0]}, 2'b01);

    wr(2'd1, 32'h0000_0021);
    wr(2'd1, 32'h0000_0531);
    rd(2'd1, v);
    chk(v[0] == 1'b1 && v[6:4] == 3'd2 && v[10:8] == 3'd0, "R12 R2 write while busy",
        v, 32'h0000_0021);
    repeat (9 * P + 10) @(negedge clk);
    rd(2'd1, v); chk(v[0] == 1'b0, "R12 no relaunch", v, 0);
    wr(2'd1, 32'h0000_0061);
    idle_check("invalid code");
    wr(2'd0, 32'h0009_0000);
    wr(2'd1, 32'h0000_0011);
    idle_check("disabled");

    wr(2'd0, 32'h0009_0003);
    stretch_period(n);
    chk(n == P + 4, "R9 stretched period", n, P + 4);
    wr(2'd0, 32'h0009_0002);
    stretch_period(n);
    chk(n == P, "R9 stretch disabled", n, P);

    wr(2'd0, 32'h8009_0002);
    chk(scl_oe && scl_o && sda_oe && sda_o, "R10 push-pull idle",
        {scl_oe, scl_o, sda_oe, sda_o}, 4'hF);
    wr(2'd0, 32'h0009_0002);
    chk(!scl_oe && !sda_oe, "R10 open-drain idle", {scl_oe, sda_oe}, 0);

    force_sda = 1'b1;
    repeat (3) @(negedge clk);
    rd(2'd0, v); chk(v[3:2] == 2'b10, "R11 live levels", v[3:2], 2'b10);
    force_sda = 1'b0;

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule